// File: doc/BRIEF.md
# Card Detect Event Tracker

This unit watches two removable-card sockets and turns pin activity into status bits, interrupt requests and queued attach/detach events. For each socket it samples two card-detect pins, two battery-voltage pins, a ready pin, a write-protect pin and the card's I/O interrupt pin. Every pin passes through a two-flop synchronizer. Edges on the synchronized pins set sticky change bits, which software acknowledges by writing ones.

A socket is considered occupied once both detect pins read high. At that point an insertion event is queued and the socket's busy flag is set. It is considered empty once both pins read low while busy, which queues a removal event and clears the flag. Events wait in a four-entry queue tagged with the socket number and the event kind, and a consumer drains the queue one pop at a time.

A card I/O interrupt is forwarded only on an occupied socket, and only while that socket's I/O enable is set. Forwarding drops the enable, so further card interrupts are held off until software writes the enable again. A per-socket mask selects which change bits drive the single shared interrupt output.

Top module: `cdtTracker`

## Requirements
- R1: After reset every change bit, mask bit, busy flag and I/O enable is 0, the event queue is empty and not full, and `irq` is 0.
- R2: A transition in either direction on a synchronized pin sets that socket's change bit: bit 0 for either detect pin, bit 1 for battery 1, bit 2 for battery 2, bit 3 for ready, bit 4 for write-protect. The live pin levels read back at bit 8 (detect 1), bit 9 (detect 2), bit 10 (ready), bit 11 (write-protect), bit 12 (battery 1) and bit 13 (battery 2). Bit 14 is busy, bit 15 is the I/O enable, and bit 7 reads 0.
- R3: A status write to the socket in `regSock` clears exactly the change bits where `wrData` has a 1. Live bits, other change bits and the other socket are left unchanged, and a change bit being set in the same cycle as its clear stays set.
- R4: When both detect pins of a non-busy socket are high, an insertion event (kind 0) carrying that socket number is queued and busy is set. A single high detect pin queues nothing.
- R5: When both detect pins of a busy socket are low, a removal event (kind 1) is queued and busy is cleared. A single low detect pin queues nothing.
- R6: A battery transition in the same cycle as a detect transition on that socket does not set the battery change bit.
- R7: A rising card interrupt on a busy socket whose I/O enable is 1 sets change bit 5 and clears the I/O enable. While the enable is 0, card interrupt edges set nothing. Writing `wrData[0]` with `ioEnWrEn` sets the enable again.
- R8: A rising card interrupt on a non-busy socket sets change bit 6 and leaves bit 5 and the I/O enable unchanged.
- R9: `irq` is high exactly when some socket has a change bit (bits 6..0) set whose mask bit is also set. The mask is written from `wrData` with `maskWrEn`.
- R10: The queue holds four events in arrival order. `evFull` is raised at four entries, and further events are dropped while busy still follows the pins. `evPop` removes the head, and a pop on an empty queue has no effect.
- R11: When both sockets have an event due in the same cycle, socket 0's event is queued first and socket 1's event in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cardDet1 | input | 2 | First detect pin, one bit per socket |
| cardDet2 | input | 2 | Second detect pin, one bit per socket |
| battLow1 | input | 2 | Battery voltage pin 1 per socket |
| battLow2 | input | 2 | Battery voltage pin 2 per socket |
| cardReady | input | 2 | Card ready pin per socket |
| wrProtect | input | 2 | Write-protect pin per socket |
| cardIrq | input | 2 | Card I/O interrupt pin per socket |
| regSock | input | 1 | Socket addressed by register writes and by `stsRd` |
| wrData | input | 7 | Write data for clear, mask and enable writes |
| stsWrEn | input | 1 | Write-one-to-clear the change bits |
| maskWrEn | input | 1 | Load the interrupt mask |
| ioEnWrEn | input | 1 | Load the I/O enable from `wrData[0]` |
| stsRd | output | 16 | Status of the addressed socket |
| irq | output | 1 | Shared interrupt request |
| evPop | input | 1 | Remove the head event |
| evEmpty | output | 1 | Event queue empty |
| evFull | output | 1 | Event queue full |
| evSock | output | 1 | Socket number of the head event |
| evKind | output | 1 | Head event kind: 0 insertion, 1 removal |

## Verification
The hardest situations to reach from the ports are coincidences: a battery edge landing in exactly the same cycle as a detect edge, both sockets becoming occupied in one cycle, and events arriving while the queue is full. The bench produces each one by driving the relevant pins on the same falling edge. The synchronizers then carry the pins together, so their edges arrive in one cycle. The overflow case is reached by toggling one socket in and out six times without popping. The bench then checks that only the first four events survive, and that the busy flag still reflects the last transition.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int NSOCK  = 2;
  localparam int SOCK_W = (NSOCK > 1) ? $clog2(NSOCK) : 1;
  localparam int NPIN   = 7;
  localparam int CHG_W  = 7;
  localparam int STS_W  = 16;

  // synchronized pin order
  localparam int P_DET1 = 0;
  localparam int P_DET2 = 1;
  localparam int P_BAT1 = 2;
  localparam int P_BAT2 = 3;
  localparam int P_RDY  = 4;
  localparam int P_WP   = 5;
  localparam int P_IRQ  = 6;

  // change bit positions
  localparam int C_DET  = 0;
  localparam int C_BAT1 = 1;
  localparam int C_BAT2 = 2;
  localparam int C_RDY  = 3;
  localparam int C_WP   = 4;
  localparam int C_IO   = 5;
  localparam int C_SPUR = 6;

  typedef enum logic {EV_INSERT = 1'b0, EV_REMOVE = 1'b1} evKind_e;

  typedef struct packed {
    logic [SOCK_W-1:0] sock;
    evKind_e           kind;
  } evEntry_t;

  typedef struct packed {
    logic             push;
    evEntry_t         entry;
    logic [NSOCK-1:0] fwd;
    logic [NSOCK-1:0] spur;
  } ctrlStrb_t;
endpackage

// File: rtl/cdtEventFifo.sv
module cdtEventFifo
  import cdt_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     push,
  input  evEntry_t pushEntry,
  input  logic     pop,
  output evEntry_t head,
  output logic     empty,
  output logic     full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  evEntry_t mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R10: a full queue without a pop keeps its head and stays full
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (full && !pop) |=> (full && $stable(head)));
  // R10: popping an empty queue leaves it empty unless something arrives
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !push) |=> empty);
endmodule

// File: rtl/cdtCtrl.sv
module cdtCtrl
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSOCK-1:0] detA,
  input  logic [NSOCK-1:0] detB,
  input  logic [NSOCK-1:0] ioEdge,
  input  logic [NSOCK-1:0] ioEn,
  output ctrlStrb_t        strb,
  output logic [NSOCK-1:0] busy
);
  logic [NSOCK-1:0] busyNext;

  always_comb begin
    logic found;
    found    = 1'b0;
    strb     = '0;
    busyNext = busy;
    for (int s = 0; s < NSOCK; s++) begin
      strb.fwd[s]  = ioEdge[s] && busy[s] && ioEn[s];
      strb.spur[s] = ioEdge[s] && !busy[s];
      if (!found && detA[s] && detB[s] && !busy[s]) begin
        found           = 1'b1;
        strb.push       = 1'b1;
        strb.entry.sock = SOCK_W'(s);
        strb.entry.kind = EV_INSERT;
        busyNext[s]     = 1'b1;
      end else if (!found && !detA[s] && !detB[s] && busy[s]) begin
        found           = 1'b1;
        strb.push       = 1'b1;
        strb.entry.sock = SOCK_W'(s);
        strb.entry.kind = EV_REMOVE;
        busyNext[s]     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busy <= '0;
    else       busy <= busyNext;
  end

  for (genvar s = 0; s < NSOCK; s++) begin : g_chk
    // R4: busy only rises with both detect pins high
    a_r4_insert_both: assert property (@(posedge clk) disable iff (!rstN)
      $rose(busy[s]) |-> $past(detA[s] && detB[s]));
    // R5: busy only falls with both detect pins low
    a_r5_remove_both: assert property (@(posedge clk) disable iff (!rstN)
      $fell(busy[s]) |-> $past(!detA[s] && !detB[s]));
  end
endmodule

// File: rtl/cdtDatapath.sv
module cdtDatapath
  import cdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSOCK-1:0] cardDet1,
  input  logic [NSOCK-1:0] cardDet2,
  input  logic [NSOCK-1:0] battLow1,
  input  logic [NSOCK-1:0] battLow2,
  input  logic [NSOCK-1:0] cardReady,
  input  logic [NSOCK-1:0] wrProtect,
  input  logic [NSOCK-1:0] cardIrq,
  input  logic [SOCK_W-1:0] regSock,
  input  logic [CHG_W-1:0] wrData,
  input  logic             stsWrEn,
  input  logic             maskWrEn,
  input  logic             ioEnWrEn,
  input  ctrlStrb_t        strb,
  input  logic [NSOCK-1:0] busy,
  output logic [NSOCK-1:0] detA,
  output logic [NSOCK-1:0] detB,
  output logic [NSOCK-1:0] ioEdge,
  output logic [NSOCK-1:0] ioEn,
  output logic [STS_W-1:0] stsRd,
  output logic             irq
);
  logic [STS_W-1:0] stsArr [NSOCK];
  logic [NSOCK-1:0] irqVec;

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    logic [NPIN-1:0]  raw, pinSync, pinPrev, edges;
    logic [NPIN-1:0]  chain [SYNC_STAGES];
    logic [CHG_W-1:0] chg, mask, setVec, clrVec;
    logic             detEdge, sel, ioEnQ;

    assign raw = {cardIrq[s], wrProtect[s], cardReady[s], battLow2[s],
                  battLow1[s], cardDet2[s], cardDet1[s]};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < SYNC_STAGES; k++) chain[k] <= '0;
        pinPrev <= '0;
      end else begin
        chain[0] <= raw;
        for (int k = 1; k < SYNC_STAGES; k++) chain[k] <= chain[k-1];
        pinPrev <= pinSync;
      end
    end

    assign pinSync = chain[SYNC_STAGES-1];
    assign edges   = pinSync ^ pinPrev;
    assign detEdge = edges[P_DET1] | edges[P_DET2];
    assign sel     = (regSock == SOCK_W'(s));

    always_comb begin
      setVec         = '0;
      setVec[C_DET]  = detEdge;
      setVec[C_BAT1] = edges[P_BAT1] && !detEdge;
      setVec[C_BAT2] = edges[P_BAT2] && !detEdge;
      setVec[C_RDY]  = edges[P_RDY];
      setVec[C_WP]   = edges[P_WP];
      setVec[C_IO]   = strb.fwd[s];
      setVec[C_SPUR] = strb.spur[s];
      clrVec = (stsWrEn && sel) ? wrData : '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chg   <= '0;
        mask  <= '0;
        ioEnQ <= 1'b0;
      end else begin
        chg <= (chg & ~clrVec) | setVec;
        if (maskWrEn && sel) mask <= wrData;
        if (strb.fwd[s])             ioEnQ <= 1'b0;
        else if (ioEnWrEn && sel)    ioEnQ <= wrData[0];
      end
    end

    assign detA[s]   = pinSync[P_DET1];
    assign detB[s]   = pinSync[P_DET2];
    assign ioEdge[s] = pinSync[P_IRQ] & ~pinPrev[P_IRQ];
    assign ioEn[s]   = ioEnQ;
    assign irqVec[s] = |(chg & mask);
    assign stsArr[s] = {ioEnQ, busy[s], pinSync[P_BAT2], pinSync[P_BAT1],
                        pinSync[P_WP], pinSync[P_RDY], pinSync[P_DET2],
                        pinSync[P_DET1], 1'b0, chg};

    // R7: a forwarded card interrupt leaves the enable cleared
    a_r7_self_mask: assert property (@(posedge clk) disable iff (!rstN)
      strb.fwd[s] |=> !ioEnQ);
    // R8: the I/O change bit never rises for a non-busy socket
    a_r8_no_fwd_idle: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chg[C_IO]) |-> $past(busy[s]));
    // R6: a detect edge suppresses a fresh battery change
    a_r6_bat_quiet: assert property (@(posedge clk) disable iff (!rstN)
      (detEdge && !chg[C_BAT1]) |=> !chg[C_BAT1]);
  end

  assign stsRd = stsArr[regSock];
  assign irq   = |irqVec;
endmodule

// File: rtl/cdtTracker.sv
module cdtTracker
  import cdt_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSOCK-1:0]  cardDet1,
  input  logic [NSOCK-1:0]  cardDet2,
  input  logic [NSOCK-1:0]  battLow1,
  input  logic [NSOCK-1:0]  battLow2,
  input  logic [NSOCK-1:0]  cardReady,
  input  logic [NSOCK-1:0]  wrProtect,
  input  logic [NSOCK-1:0]  cardIrq,
  input  logic [SOCK_W-1:0] regSock,
  input  logic [CHG_W-1:0]  wrData,
  input  logic              stsWrEn,
  input  logic              maskWrEn,
  input  logic              ioEnWrEn,
  output logic [STS_W-1:0]  stsRd,
  output logic              irq,
  input  logic              evPop,
  output logic              evEmpty,
  output logic              evFull,
  output logic [SOCK_W-1:0] evSock,
  output logic              evKind
);
  ctrlStrb_t        strb;
  logic [NSOCK-1:0] busy, detA, detB, ioEdge, ioEn;
  evEntry_t         head;

  cdtDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .cardDet1(cardDet1), .cardDet2(cardDet2), .battLow1(battLow1),
    .battLow2(battLow2), .cardReady(cardReady), .wrProtect(wrProtect),
    .cardIrq(cardIrq), .regSock(regSock), .wrData(wrData),
    .stsWrEn(stsWrEn), .maskWrEn(maskWrEn), .ioEnWrEn(ioEnWrEn),
    .strb(strb), .busy(busy), .detA(detA), .detB(detB),
    .ioEdge(ioEdge), .ioEn(ioEn), .stsRd(stsRd), .irq(irq)
  );

  cdtCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .detA(detA), .detB(detB),
    .ioEdge(ioEdge), .ioEn(ioEn), .strb(strb), .busy(busy)
  );

  cdtEventFifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .push(strb.push), .pushEntry(strb.entry),
    .pop(evPop), .head(head), .empty(evEmpty), .full(evFull)
  );

  assign evSock = head.sock;
  assign evKind = head.kind;
endmodule

// File: tb/test_cdtTracker.sv
`timescale 1ns/1ps
module test_cdtTracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cardDet1 = '0, cardDet2 = '0, battLow1 = '0, battLow2 = '0;
  logic [1:0] cardReady = '0, wrProtect = '0, cardIrq = '0;
  logic       regSock = 1'b0;
  logic [6:0] wrData = '0;
  logic stsWrEn = 0, maskWrEn = 0, ioEnWrEn = 0, evPop = 0;
  logic [15:0] stsRd;
  logic irq, evEmpty, evFull, evSock, evKind;
  int total = 0, fails = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  cdtTracker i_cdtTracker (
    .clk(clk), .rstN(rstN), .cardDet1(cardDet1), .cardDet2(cardDet2),
    .battLow1(battLow1), .battLow2(battLow2), .cardReady(cardReady),
    .wrProtect(wrProtect), .cardIrq(cardIrq), .regSock(regSock),
    .wrData(wrData), .stsWrEn(stsWrEn), .maskWrEn(maskWrEn),
    .ioEnWrEn(ioEnWrEn), .stsRd(stsRd), .irq(irq), .evPop(evPop),
    .evEmpty(evEmpty), .evFull(evFull), .evSock(evSock), .evKind(evKind)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic getSts(input int s, output logic [15:0] r);
    regSock = s[0];
    #1;
    r = stsRd;
  endtask

  task automatic regWr(input int s, input int kind, input logic [6:0] d);
    @(negedge clk);
    regSock = s[0];
    wrData  = d;
    stsWrEn = (kind == 0);
    maskWrEn = (kind == 1);
    ioEnWrEn = (kind == 2);
    @(negedge clk);
    stsWrEn = 0; maskWrEn = 0; ioEnWrEn = 0;
  endtask

  task automatic clrAll();
    regWr(0, 0, 7'h7f);
    regWr(1, 0, 7'h7f);
  endtask

  task automatic popChk(input string req, input logic s, input logic k);
    chk({req, " not empty"}, evEmpty, 1'b0);
    chk({req, " sock"}, evSock, s);
    chk({req, " kind"}, evKind, k);
    evPop = 1;
    @(negedge clk);
    evPop = 0;
  endtask

  task automatic setPin(input int p, input int s, input logic val);
    case (p)
      0: battLow1[s]  = val;
      1: battLow2[s]  = val;
      2: cardReady[s] = val;
      default: wrProtect[s] = val;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 empty", evEmpty, 1);
    chk("R1 full", evFull, 0);
    for (int s = 0; s < 2; s++) begin
      getSts(s, v);
      chk("R1 status", v, 16'h0);
    end

    // R2 sweep: battery 1, battery 2, ready, write-protect on both sockets
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 4; p++) begin
        int chgBit, liveBit;
        chgBit  = p + 1;
        liveBit = (p == 0) ? 12 : (p == 1) ? 13 : (p == 2) ? 10 : 11;
        @(negedge clk); setPin(p, s, 1'b1);
        tick(6);
        getSts(s, v);
        chk("R2 rise set", v, (32'h1 << chgBit) | (32'h1 << liveBit));
        getSts(1 - s, v);
        chk("R2 other socket quiet", v & 16'h7f, 0);
        regWr(s, 0, 7'h7f);
        getSts(s, v);
        chk("R3 clear keeps live", v, 32'h1 << liveBit);
        @(negedge clk); setPin(p, s, 1'b0);
        tick(6);
        getSts(s, v);
        chk("R2 fall set", v, 32'h1 << chgBit);
        regWr(s, 0, 7'h7f);
      end
    end

    // R3 partial clear, other socket untouched
    @(negedge clk); cardReady = 2'b11; wrProtect = 2'b01;
    tick(6);
    regWr(0, 0, 7'h08);
    getSts(0, v);
    chk("R3 partial clear", v, 16'h0c10);
    getSts(1, v);
    chk("R3 other socket kept", v, 16'h0408);

    // R9 mask
    chk("R9 unmasked irq low", irq, 0);
    regWr(1, 1, 7'h08);
    chk("R9 masked bit drives irq", irq, 1);
    regWr(1, 1, 7'h10);
    chk("R9 other bit no irq", irq, 0);
    regWr(0, 1, 7'h10);
    chk("R9 socket0 wp irq", irq, 1);
    regWr(0, 1, 7'h00); regWr(1, 1, 7'h00);
    @(negedge clk); cardReady = 2'b00; wrProtect = 2'b00;
    tick(6);
    clrAll();

    // R4 insertion on socket 0
    @(negedge clk); cardDet1[0] = 1;
    tick(8);
    chk("R4 single pin no event", evEmpty, 1);
    getSts(0, v);
    chk("R4 single pin not busy", v[14], 0);
    @(negedge clk); cardDet2[0] = 1;
    tick(8);
    getSts(0, v);
    chk("R4 busy set", v[14], 1);
    popChk("R4 insert", 1'b0, 1'b0);
    chk("R4 drained", evEmpty, 1);

    // R5 removal on socket 0
    @(negedge clk); cardDet1[0] = 0;
    tick(8);
    chk("R5 single low no event", evEmpty, 1);
    @(negedge clk); cardDet2[0] = 0;
    tick(8);
    getSts(0, v);
    chk("R5 busy clear", v[14], 0);
    popChk("R5 remove", 1'b0, 1'b1);
    clrAll();

    // R11 simultaneous insertion on both sockets
    @(negedge clk); cardDet1 = 2'b11; cardDet2 = 2'b11;
    tick(8);
    popChk("R11 first", 1'b0, 1'b0);
    popChk("R11 second", 1'b1, 1'b0);
    chk("R11 drained", evEmpty, 1);
    clrAll();

    // R6 battery edge coincident with detect edge on socket 1
    @(negedge clk); cardDet1[1] = 0; battLow1[1] = 1;
    tick(6);
    getSts(1, v);
    chk("R6 battery suppressed", v[6:0], 7'h01);
    @(negedge clk); cardDet1[1] = 1;
    tick(6);
    regWr(1, 0, 7'h7f);
    @(negedge clk); battLow1[1] = 0;
    tick(6);
    getSts(1, v);
    chk("R6 lone battery edge", v[6:0], 7'h02);
    chk("R6 no event", evEmpty, 1);
    clrAll();

    // R7 I/O forwarding on busy socket 0
    regWr(0, 2, 7'h01);
    regWr(0, 1, 7'h20);
    getSts(0, v);
    chk("R7 enable set", v[15], 1);
    @(negedge clk); cardIrq[0] = 1;
    tick(6);
    getSts(0, v);
    chk("R7 forwarded bit", v[5], 1);
    chk("R7 enable dropped", v[15], 0);
    chk("R9 io irq", irq, 1);
    @(negedge clk); cardIrq[0] = 0;
    tick(4);
    regWr(0, 0, 7'h20);
    @(negedge clk); cardIrq[0] = 1;
    tick(6);
    getSts(0, v);
    chk("R7 masked edge ignored", v[6:0], 7'h00);
    chk("R7 irq quiet", irq, 0);
    @(negedge clk); cardIrq[0] = 0;
    tick(4);
    regWr(0, 2, 7'h01);
    @(negedge clk); cardIrq[0] = 1;
    tick(6);
    getSts(0, v);
    chk("R7 re-enabled forwards", v[6:0], 7'h20);
    @(negedge clk); cardIrq[0] = 0;
    regWr(0, 1, 7'h00);
    clrAll();

    // R8 spurious on socket 1 after removal
    @(negedge clk); cardDet1[1] = 0; cardDet2[1] = 0;
    tick(8);
    popChk("R8 setup remove", 1'b1, 1'b1);
    regWr(1, 2, 7'h01);
    regWr(1, 0, 7'h7f);
    @(negedge clk); cardIrq[1] = 1;
    tick(6);
    getSts(1, v);
    chk("R8 spurious bit only", v[6:0], 7'h40);
    chk("R8 enable unchanged", v[15], 1);
    @(negedge clk); cardIrq[1] = 0;
    tick(4);
    clrAll();

    // R10 overflow: six events on socket 1 without popping
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); cardDet1[1] = ~cardDet1[1]; cardDet2[1] = ~cardDet2[1];
      tick(8);
    end
    chk("R10 full", evFull, 1);
    getSts(1, v);
    chk("R10 busy follows pins", v[14], 0);
    for (int i = 0; i < 4; i++) popChk("R10 order", 1'b1, i[0]);
    chk("R10 empty after drain", evEmpty, 1);
    chk("R10 not full after drain", evFull, 0);
    evPop = 1; @(negedge clk); evPop = 0;
    chk("R10 pop on empty", evEmpty, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule